// File: doc/BRIEF.md
# Lookup-Table Sequencer

This block is a state machine whose entire next-state function sits in a writable lookup table. The present state and the synchronised input lines together form the table address: the state occupies the low address bits and the inputs the high ones. On each enabled clock, the word read from that address is loaded back into the state register. The state register bits are also the machine's output bus. When a state's code is chosen to match the pattern its outputs need, the outputs need no decode logic.

A host or testbench loads the table through a synchronous write port while the machine is paused (`run_en` low). Once the host raises `run_en`, the machine takes one table step per clock. Table locations that were never written since reset read as zero. Zero is the default state, so any input/state pair without a listed transition falls back to it. The external inputs pass through a two-flop synchroniser before they reach the address. There is therefore no combinational path from the inputs to the outputs.

Top module: `table_fsm`

## Requirements
- R1: The lookup address is {synchronised inputs, present state}. The state code fills bits [STATE_W-1:0] and the inputs fill bits [ADDR_W-1:STATE_W]. The same state therefore leads to different next states under different input values.
- R2: On a rising edge with `rst_n` and `run_en` both high, the state register loads the word stored at the current address.
- R3: `state_out` is the state register itself. It changes only on rising clock edges.
- R4: Reset is synchronous and active low. It sets the state to code 0, clears both synchroniser stages to 0, and marks every table entry as unwritten.
- R5: A table entry that has not been written since reset reads as code 0. An unlisted transition therefore goes to the default state 0.
- R6: A write (`wr_en` high with `run_en` low) stores `wr_data` at `wr_addr`. Later lookups of that address return the stored word.
- R7: A write request made while `run_en` is high is ignored. Later lookups of that address still return the earlier contents.
- R8: While `run_en` is low, the state register holds its value, whatever the inputs or table writes do.
- R9: A change on `in_raw` sampled at rising edge k reaches the address after edge k+1. It first affects `state_out` at edge k+2.
- R10: With the default STATE_W of 8, all 256 codes, including 0xFF, can be stored and reached as states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | High: take one table step per clock; low: hold state, allow writes |
| in_raw | input | IN_W | Asynchronous condition inputs |
| wr_en | input | 1 | Table write strobe (honoured only while run_en is low) |
| wr_addr | input | STATE_W+IN_W | Table write address {inputs, state} |
| wr_data | input | STATE_W | Next-state code to store |
| state_out | output | STATE_W | Registered state, used directly as the output pattern |

## Verification
A four-phase rotation table is loaded and first driven with the forward input code and then with the reverse code. Since both pass through the same states, this shows that the input bits take part in the address. A hold code that maps each state to itself separates "stepping to the same state" from "paused by run_en". An input code with no entries, together with the reset that follows, exercises the fall-back to state 0 and shows that the table is cleared. A write attempted while running, and a reachable 0xFF state, guard against dropped write gating and truncated state bits. Input changes are placed on chosen cycles so that a missing or extra synchroniser stage shifts the reaction by one clock.

// File: rtl/table_fsm_pkg.sv
// Package: shared defaults for the lookup-table sequencer.
// Assumes: consumers derive all widths from these two values.
package table_fsm_pkg;
    localparam int STATE_W_DEF = 8;
    localparam int IN_W_DEF    = 2;

    // Compose a table address from input code and state code (inputs high).
    function automatic logic [STATE_W_DEF+IN_W_DEF-1:0] make_addr(
        input logic [IN_W_DEF-1:0]    cond,
        input logic [STATE_W_DEF-1:0] st
    );
        return {cond, st};
    endfunction
endpackage

// File: rtl/tfsm_in_sync.sv
// Module: tfsm_in_sync
// Two-flop synchroniser for the condition inputs, one per bit via generate.
// Assumes: in_raw may change at any time; reset is synchronous, active low.
module tfsm_in_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_raw,
    output logic [W-1:0] in_s
);
    logic [W-1:0] stage_a;
    logic [W-1:0] stage_b;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Shift one input bit through the two capture stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_a[g] <= 1'b0;
                stage_b[g] <= 1'b0;
            end else begin
                stage_a[g] <= in_raw[g];
                stage_b[g] <= stage_a[g];
            end
        end
    end

    assign in_s = stage_b;

    // R9
    sync_first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stage_a == $past(in_raw));
    // R9
    sync_second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stage_b == $past(stage_a));
endmodule

// File: rtl/tfsm_table.sv
// Module: tfsm_table
// Transition table: asynchronous read, synchronous gated write, and a
// per-entry written flag so unwritten entries read as the default code 0.
// Assumes: writes are only accepted while the machine is paused.
module tfsm_table #(
    parameter int STATE_W = 8,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [STATE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [STATE_W-1:0] rd_data,
    output logic               rd_hit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [STATE_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]   vld_q;
    logic               wr_ok;

    assign wr_ok = wr_en && !run_en;

    // Store the next-state word on an accepted write.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Track which entries hold a written word since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_ok) begin
            vld_q[wr_addr] <= 1'b1;
        end
    end

    // Read the addressed entry, falling back to code 0 if unwritten.
    always_comb begin
        rd_hit  = vld_q[rd_addr];
        rd_data = rd_hit ? mem_q[rd_addr] : '0;
    end

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !run_en) |=>
            (vld_q[$past(wr_addr)] && mem_q[$past(wr_addr)] == $past(wr_data)));
    // R7
    run_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && run_en) |=>
            (vld_q[$past(wr_addr)] == $past(vld_q[wr_addr])));
endmodule

// File: rtl/tfsm_state_reg.sv
// Module: tfsm_state_reg
// State register: loads the looked-up code when enabled, else holds.
// Assumes: next_d is already resolved to the default on unwritten entries.
module tfsm_state_reg #(
    parameter int STATE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [STATE_W-1:0] next_d,
    output logic [STATE_W-1:0] state_q
);
    // Advance one table step per enabled clock; reset to default code 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (run_en) begin
            state_q <= next_d;
        end
    end

    // R4
    reset_to_default_chk: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);
    // R8
    paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !run_en) |=> $stable(state_q));
endmodule

// File: rtl/table_fsm.sv
// Module: table_fsm (top)
// Memory-table driven state machine: address = {synced inputs, state};
// the looked-up word becomes the next state and the state is the output.
// Assumes: the table is loaded with run_en low before running.
module table_fsm
    import table_fsm_pkg::*;
#(
    parameter int STATE_W = STATE_W_DEF,
    parameter int IN_W    = IN_W_DEF,
    localparam int ADDR_W = STATE_W + IN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [IN_W-1:0]    in_raw,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [STATE_W-1:0] wr_data,
    output logic [STATE_W-1:0] state_out
);
    logic [IN_W-1:0]    in_s;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] next_d;
    logic [ADDR_W-1:0]  lut_addr;
    logic               tbl_hit;

    tfsm_in_sync #(.W(IN_W)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_raw (in_raw),
        .in_s   (in_s)
    );

    // Form the lookup address: state in the low bits, inputs in the high bits.
    assign lut_addr = {in_s, state_q};

    tfsm_table #(.STATE_W(STATE_W), .ADDR_W(ADDR_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (lut_addr),
        .rd_data (next_d),
        .rd_hit  (tbl_hit)
    );

    tfsm_state_reg #(.STATE_W(STATE_W)) state_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .next_d  (next_d),
        .state_q (state_q)
    );

    assign state_out = state_q;

    // R5
    unlisted_to_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && run_en && !tbl_hit) |=> state_out == '0);
    // R2
    step_follows_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && run_en && tbl_hit) |=> state_out == $past(next_d));
    // R3
    output_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !run_en) |=> state_out == $past(state_out));
endmodule

// File: tb/table_fsm_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module table_fsm_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int IW = 2;
    localparam int AW = SW + IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [IW-1:0] in_raw = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [SW-1:0] wr_data = '0;
    logic [SW-1:0] state_out;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R4";
    bit    done = 1'b0;

    // reference model state
    int m_tab [1 << AW];
    bit m_vld [1 << AW];
    int m_st = 0;
    int m_s1 = 0;
    int m_s2 = 0;

    table_fsm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .in_raw    (in_raw),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .state_out (state_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model: update on each rising edge from the stable inputs.
    always @(posedge clk) begin
        int nxt;
        int a;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < (1 << AW); i++) m_vld[i] = 1'b0;
        end else begin
            nxt = m_st;
            if (run_en) begin
                a = m_s2 * 256 + m_st;
                nxt = m_vld[a] ? m_tab[a] : 0;
            end else if (wr_en) begin
                m_tab[wr_addr] = wr_data;
                m_vld[wr_addr] = 1'b1;
            end
            m_s2 = m_s1;
            m_s1 = in_raw;
            m_st = nxt;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: state_out actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare the design with the model at every falling edge.
    always @(negedge clk) begin
        if (!done && cyc > 0) check(tag, state_out, m_st);
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input int cond, input int st, input int nxt);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(cond * 256 + st); wr_data = SW'(nxt);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R4: reset state
        tag = "R4";
        ticks(3);
        check("R4", state_out, 0);
        rst_n = 1'b1;
        // R5: empty table keeps machine in default state
        tag = "R5";
        run_en = 1'b1; in_raw = 2'd1;
        ticks(6);
        check("R5", state_out, 0);
        // R6/R8: load forward (cond 1), reverse (cond 2), hold (cond 0) tables
        tag = "R6";
        run_en = 1'b0;
        put(1, 8'h00, 8'h01); put(1, 8'h01, 8'h02); put(1, 8'h02, 8'h04);
        put(1, 8'h04, 8'h08); put(1, 8'h08, 8'h01);
        put(2, 8'h00, 8'h08); put(2, 8'h08, 8'h04); put(2, 8'h04, 8'h02);
        put(2, 8'h02, 8'h01); put(2, 8'h01, 8'h08);
        tag = "R8";
        in_raw = 2'd2;
        put(0, 8'h01, 8'h01); put(0, 8'h02, 8'h02);
        put(0, 8'h04, 8'h04); put(0, 8'h08, 8'h08);
        check("R8", state_out, 0);
        // R2/R3: forward rotation
        tag = "R2";
        in_raw = 2'd1;
        ticks(3);
        run_en = 1'b1;
        ticks(7);
        // R1: same states, reverse input code changes the path
        tag = "R1";
        in_raw = 2'd2;
        ticks(7);
        // R9: hold code; reaction timing checked every cycle by the model
        tag = "R9";
        in_raw = 2'd0;
        ticks(1);
        check("R9", state_out, m_st);
        ticks(5);
        // R7: write while running must not land
        tag = "R7";
        wr_en = 1'b1; wr_addr = AW'(1 * 256 + 8'h01); wr_data = 8'h55;
        ticks(1);
        wr_en = 1'b0;
        in_raw = 2'd1;
        ticks(8);
        // R5: unlisted input code 3 sends machine to state 0
        tag = "R5";
        in_raw = 2'd3;
        ticks(4);
        check("R5", state_out, 0);
        // R10: reach code 0xFF and back
        tag = "R10";
        run_en = 1'b0;
        put(1, 8'h08, 8'hFF); put(1, 8'hFF, 8'h80); put(1, 8'h80, 8'h00);
        in_raw = 2'd1;
        ticks(3);
        run_en = 1'b1;
        ticks(10);
        // R8: pause with moving inputs
        tag = "R8";
        run_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            in_raw = IW'(k);
            ticks(1);
        end
        // R4: reset mid-run clears table
        tag = "R4";
        run_en = 1'b1;
        rst_n = 1'b0;
        ticks(2);
        check("R4", state_out, 0);
        rst_n = 1'b1; in_raw = 2'd1;
        ticks(6);
        check("R4", state_out, 0);
        finish_run();
    end
endmodule